// File: doc/BRIEF.md
# Serial Bus Bit Timing Synchronizer

This block recovers bit timing from a wired-AND serial bus, where a dominant level is logic 0 and a recessive level is logic 1. It counts system clocks into time quanta and groups the quanta into a bit. The bit has a one-quantum sync segment, then a propagation segment, then phase segment 1, then phase segment 2. The line is sampled at the end of phase segment 1, and the bit value is given to the frame logic together with a one-cycle strobe. A second strobe marks the start of each sync segment, so the transmit path can drive its next bit there.

The local bit clock follows the remote transmitter by watching falling edges of the line. While the frame logic reports an idle bus or start of frame, an edge restarts the bit time (hard synchronization). Later edges move the sample point by no more than the jump width (resynchronization), and these are ignored while the node drives a dominant bit itself. An optional mode takes three samples and uses their majority.

Top module: `bit_sync`

## Requirements
- R1: One time quantum lasts 2*(brp+1) clocks. With no edge on `rx_in`, `tx_stb` pulses for one cycle once per bit, and consecutive pulses are (1+Tp+T1+T2) quanta apart.
- R2: The segment lengths are Tp=`prop_seg`+1 and T1=`ph1_seg`+1. T2 is `ph2_seg`+1, except that an encoding of 0 gives 2 quanta. The jump width is J=`sjw`+1. With no edge, `sample_stb` pulses (Tp+T1+1) quanta after `tx_stb`, and it never pulses in the same cycle as `tx_stb`.
- R3: `rx_in` passes through two registers before edge detection. A falling edge seen while `sof_en` is high restarts the bit at the start of the sync segment, without a `tx_stb`. The next `sample_stb` then comes 2+(Tp+T1+1)*2*(brp+1) clocks after the low level is presented.
- R4: A resynchronizing edge that falls in quantum q, where 1 <= q <= the sample quantum, delays the sample point and the bit end by min(q, J) quanta.
- R5: A resynchronizing edge after the sample point, with r quanta of the bit left (current one included), shortens phase segment 2 by J when r > J. When r <= J it ends the bit at once and starts a new sync segment, and `tx_stb` pulses.
- R6: While `tx_dom` is high, falling edges cause no resynchronization. Hard synchronization is unaffected.
- R7: After a synchronization of either kind, further edges are ignored until the next sample point.
- R8: With `triple_en` high, `rx_bit` takes the majority of the line at the ends of the sample quantum and of the two quanta before it.
- R9: With `triple_en` low, `rx_bit` takes the line value at the end of the sample quantum. `rx_bit` changes only in a cycle where `sample_stb` is high.
- R10: During reset, `rx_bit` is 1 and both strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_in | input | 1 | Raw bus receive line (0 = dominant) |
| brp | input | BRP_W | Prescaler; quantum = 2*(brp+1) clocks |
| prop_seg | input | SEG_W | Propagation segment length minus one |
| ph1_seg | input | SEG_W | Phase segment 1 length minus one |
| ph2_seg | input | SEG_W | Phase segment 2 length minus one (0 means 2 quanta) |
| sjw | input | SJW_W | Jump width minus one |
| triple_en | input | 1 | Three-sample majority enable |
| tx_dom | input | 1 | Node is driving a dominant bit |
| sof_en | input | 1 | Bus idle / start of frame: edges hard-synchronize |
| rx_bit | output | 1 | Sampled bit value |
| sample_stb | output | 1 | One-cycle pulse when `rx_bit` is updated |
| tx_stb | output | 1 | One-cycle pulse at start of sync segment |

## Verification
The bench sends frames from a transmitter whose bit length is a few clocks too long, too short, or jittered, so edges land on both sides of the sample point. It covers the boundary where the time left in phase segment 2 equals the jump width: a design that gets this wrong samples a quantum late or sends an extra transmit strobe. Short pulses placed twice in one bit check that only the first edge is used and that the majority vote filters a one-quantum glitch. A design that resynchronizes twice, or that votes over the wrong quanta, moves `sample_stb` or flips `rx_bit`. The bench also holds `tx_dom` high during edges and uses the smallest encodings, including the phase segment 2 encoding of 0. Errors there show up as a wrong bit period or an early sample.

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int BRP_W = 6,
  parameter int SEG_W = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_in,
  input  logic [BRP_W-1:0] brp,
  input  logic [SEG_W-1:0] prop_seg,
  input  logic [SEG_W-1:0] ph1_seg,
  input  logic [SEG_W-1:0] ph2_seg,
  input  logic [SJW_W-1:0] sjw,
  input  logic             triple_en,
  input  logic             tx_dom,
  input  logic             sof_en,
  output logic             rx_bit,
  output logic             sample_stb,
  output logic             tx_stb
);
  localparam int PW = BRP_W + 1;
  localparam int QW = $clog2(3 * (1 << SEG_W) + (1 << SJW_W) + 1);

  logic [PW-1:0] pre;
  logic [QW-1:0] q, ext, shr;
  logic          ok, rx_s, rx_d;
  logic [1:0]    sh;

  wire [QW-1:0] t1   = QW'(prop_seg) + QW'(ph1_seg) + QW'(2);
  wire [QW-1:0] t2   = (ph2_seg == '0) ? QW'(2) : QW'(ph2_seg) + QW'(1);
  wire [QW-1:0] jw   = QW'(sjw) + QW'(1);
  wire          tick = (pre == {brp, 1'b1});
  wire          fall = rx_d & ~rx_s;
  wire          hs   = fall & ok & sof_en;
  wire          rs   = fall & ok & ~sof_en & ~tx_dom;

  wire [QW-1:0] s_pt  = t1 + ext;
  wire [QW-1:0] b_pt  = s_pt + t2 - shr;
  wire          late  = rs && (q != '0) && (q <= s_pt);
  wire          early = rs && (q > s_pt);
  wire [QW-1:0] rem   = b_pt - q + QW'(1);
  wire          cut   = early && (rem <= jw);
  wire [QW-1:0] add   = (q < jw) ? q : jw;

  wire [QW-1:0] s_eff = late ? s_pt + add : s_pt;
  wire [QW-1:0] b_eff = late ? b_pt + add : (early && !cut) ? b_pt - jw : b_pt;

  wire smp = tick && !hs && !cut && (q == s_eff);
  wire eob = tick && !hs && !cut && (q == b_eff);
  wire maj = (sh[1] & sh[0]) | (sh[1] & rx_s) | (sh[0] & rx_s);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre        <= '0;
      q          <= '0;
      ext        <= '0;
      shr        <= '0;
      ok         <= 1'b1;
      rx_s       <= 1'b1;
      rx_d       <= 1'b1;
      sh         <= 2'b11;
      rx_bit     <= 1'b1;
      sample_stb <= 1'b0;
      tx_stb     <= 1'b0;
    end else begin
      rx_s       <= rx_in;
      rx_d       <= rx_s;
      sample_stb <= smp;
      tx_stb     <= eob | cut;
      if (tick) sh <= {sh[0], rx_s};
      if (smp) rx_bit <= triple_en ? maj : rx_s;
      if (hs || rs) ok <= 1'b0;
      else if (smp) ok <= 1'b1;
      if (hs || cut) begin
        pre <= '0;
        q   <= '0;
        ext <= '0;
        shr <= '0;
      end else begin
        pre <= tick ? '0 : pre + PW'(1);
        if (late)  ext <= add;
        if (early) shr <= jw;
        if (eob) begin
          q   <= '0;
          ext <= '0;
          shr <= '0;
        end else if (tick) begin
          q <= q + QW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/bit_sync_chk.sv
module bit_sync_chk #(
  parameter int QW = 5,
  parameter int PW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sample_stb,
  input logic          tx_stb,
  input logic          rx_bit,
  input logic          hs,
  input logic [QW-1:0] ext,
  input logic [QW-1:0] jw,
  input logic [QW-1:0] q,
  input logic [PW-1:0] pre
);
  p_tx_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_stb |=> !tx_stb);

  p_strobes_apart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |-> !tx_stb);

  p_hard_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hs |=> (q == '0 && pre == '0));

  p_ext_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ext <= jw);

  p_bit_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_stb |-> $stable(rx_bit));
endmodule

bind bit_sync bit_sync_chk #(.QW(QW), .PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .tx_stb(tx_stb),
  .rx_bit(rx_bit), .hs(hs), .ext(ext), .jw(jw), .q(q), .pre(pre)
);

// File: tb/test_bit_sync.sv
`timescale 1ns/1ps
module test_bit_sync;
  logic       clk = 0, rst_n = 0, rx = 1;
  logic [5:0] brp = 1;
  logic [2:0] prop = 1, ph1 = 2, ph2 = 2;
  logic [1:0] sjw = 1;
  logic       triple = 0, txd = 0, sof = 0;
  logic       rx_bit, sample_stb, tx_stb;
  int checks = 0, errors = 0;
  bit done = 0, run = 0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  bit_sync i_bit_sync (
    .clk(clk), .rst_n(rst_n), .rx_in(rx), .brp(brp), .prop_seg(prop),
    .ph1_seg(ph1), .ph2_seg(ph2), .sjw(sjw), .triple_en(triple),
    .tx_dom(txd), .sof_en(sof), .rx_bit(rx_bit), .sample_stb(sample_stb),
    .tx_stb(tx_stb)
  );

  int m_pre, m_q, m_ext, m_shr;
  bit m_ok, m_s, m_d, m_sh0, m_sh1, m_bit, m_ss, m_ts;

  always @(posedge clk) begin : model
    int qn, sp, bp, t2, j, np, nq, ne, nsh, rem;
    bit tk, fl, skip, mj, nok;
    if (!rst_n) begin
      m_pre = 0; m_q = 0; m_ext = 0; m_shr = 0; m_ok = 1;
      m_s = 1; m_d = 1; m_sh0 = 1; m_sh1 = 1; m_bit = 1; m_ss = 0; m_ts = 0;
    end else begin
      qn = 2 * (int'(brp) + 1);
      tk = (m_pre == qn - 1);
      fl = m_d && !m_s;
      t2 = (ph2 == 0) ? 2 : int'(ph2) + 1;
      j  = int'(sjw) + 1;
      sp = int'(prop) + int'(ph1) + 2 + m_ext;
      bp = sp + t2 - m_shr;
      mj = (m_sh1 + m_sh0 + m_s) >= 2;
      np = tk ? 0 : m_pre + 1;
      nq = m_q; ne = m_ext; nsh = m_shr; nok = m_ok;
      skip = 0; m_ss = 0; m_ts = 0;
      if (fl && m_ok && sof) begin
        np = 0; nq = 0; ne = 0; nsh = 0; nok = 0; skip = 1;
      end else if (fl && m_ok && !txd) begin
        nok = 0;
        if (m_q > 0 && m_q <= sp) begin
          ne = (m_q < j) ? m_q : j;
          sp += ne; bp += ne;
        end else if (m_q > sp) begin
          rem = bp - m_q + 1;
          if (rem <= j) begin
            np = 0; nq = 0; ne = 0; nsh = 0; m_ts = 1; skip = 1;
          end else begin
            nsh = j; bp -= j;
          end
        end
      end
      if (!skip && tk) begin
        if (m_q == sp) begin
          m_ss = 1; m_bit = triple ? mj : m_s; nok = 1;
        end
        if (m_q == bp) begin
          nq = 0; ne = 0; nsh = 0; m_ts = 1;
        end else nq = m_q + 1;
      end
      if (tk) begin m_sh1 = m_sh0; m_sh0 = m_s; end
      m_d = m_s; m_s = rx;
      m_pre = np; m_q = nq; m_ext = ne; m_shr = nsh; m_ok = nok;
    end
  end

  always @(negedge clk) begin
    if (rst_n && run && !done) begin
      checks++;
      if (rx_bit !== m_bit || sample_stb !== m_ss || tx_stb !== m_ts) begin
        errors++;
        $display("FAIL %s: bit/smp/tx actual=%b%b%b expected=%b%b%b at %0t",
                 cur_req, rx_bit, sample_stb, tx_stb, m_bit, m_ss, m_ts, $time);
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_tx();
    do @(negedge clk); while (!tx_stb);
  endtask

  task automatic period_check();
    int n, qn, s, nb;
    qn = 2 * (int'(brp) + 1);
    s  = int'(prop) + int'(ph1) + 2;
    nb = 1 + s + ((ph2 == 0) ? 2 : int'(ph2) + 1);
    wait_tx();
    n = 0;
    do begin @(negedge clk); n++; end while (!sample_stb);
    check("R2 sample offset", n, (s + 1) * qn);
    do begin @(negedge clk); n++; end while (!tx_stb);
    check("R1 bit period", n, nb * qn);
  endtask

  task automatic set_cfg(input int b, input int p, input int a, input int c, input int w);
    wait_tx();
    brp = 6'(b); prop = 3'(p); ph1 = 3'(a); ph2 = 3'(c); sjw = 2'(w);
  endtask

  task automatic frame(input int nbits, input int len, input int jit, input int txmode);
    for (int i = 0; i < nbits; i++) begin
      int l;
      rx  = (i % 3 == 2) ? 1'b1 : 1'(($urandom % 2));
      if (i % 2 == 0) rx = 1'b0;
      txd = (txmode == 2) ? 1'($urandom % 2) : 1'(txmode);
      l = len + ((jit > 0) ? int'($urandom % (2 * jit + 1)) - jit : 0);
      repeat (l) @(negedge clk);
    end
    rx = 1; txd = 0;
  endtask

  task automatic glitches(input int n, input int w, input int gap);
    for (int i = 0; i < n; i++) begin
      rx = 0; repeat (w) @(negedge clk);
      rx = 1; repeat (gap + int'($urandom % 7)) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 rx_bit", rx_bit, 1);
    check("R10 sample_stb", sample_stb, 0);
    check("R10 tx_stb", tx_stb, 0);
    rst_n = 1; run = 1;
    cur_req = "R1 R2";
    repeat (40) @(negedge clk);
    period_check();
    period_check();

    cur_req = "R3";
    repeat (7) @(negedge clk);
    sof = 1; rx = 0;
    begin
      int qn = 2 * (int'(brp) + 1);
      int s  = int'(prop) + int'(ph1) + 2;
      repeat (2 + (s + 1) * qn - 1) @(negedge clk);
      check("R3 no early sample", sample_stb, 0);
      @(negedge clk);
      check("R3 sample after hard sync", sample_stb, 1);
    end
    sof = 0;
    repeat (20) @(negedge clk);
    rx = 1;
    repeat (60) @(negedge clk);

    cur_req = "R4 R9";
    frame(25, 36 + 3, 0, 0);
    sjw = 0;
    frame(25, 36 + 5, 0, 0);
    cur_req = "R5 R9";
    sjw = 1;
    frame(25, 36 - 3, 0, 0);
    sjw = 3;
    frame(25, 36 - 6, 0, 0);
    cur_req = "R5 R7";
    frame(40, 36, 8, 0);
    cur_req = "R6";
    frame(30, 36 - 5, 0, 1);
    frame(30, 36, 8, 2);
    cur_req = "R7";
    sjw = 1;
    glitches(40, 3, 6);
    cur_req = "R8";
    triple = 1; txd = 1;
    glitches(40, 4, 20);
    txd = 0;
    frame(30, 36, 6, 0);
    triple = 0;

    cur_req = "R2";
    set_cfg(0, 0, 0, 0, 0);
    period_check();
    period_check();
    cur_req = "R4 R5 R8";
    triple = 1;
    frame(40, 10, 2, 0);
    triple = 0;
    cur_req = "R2";
    set_cfg(3, 7, 7, 7, 3);
    period_check();
    cur_req = "R4 R5 R7";
    frame(30, 200, 20, 0);
    cur_req = "R3";
    rx = 1;
    repeat (300) @(negedge clk);
    sof = 1;
    frame(10, 200, 10, 0);
    sof = 0;
    repeat (400) @(negedge clk);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(190_000 * 4);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule